// File: doc/BRIEF.md
# Sensor-Guided Voltage and Frequency Tuning Controller

This block is a control state machine. It carries out power-saving and performance-raising requests on two operating codes: a digital main-rail voltage code and a clock frequency code. It does not jump to a precomputed table entry. Instead, it searches at run time for the just-enough operating point.

During each risky move it enables a set of delay-error prediction sensors. It then walks the relevant code one least-significant step at a time until any sensor predicts a timing error. It then backs away by a programmable safety margin and switches the sensors off again. No error recovery is needed, because errors are predicted rather than detected after the fact.

A save request first lowers the frequency directly. Only after that does it search the voltage downward. A boost request first raises the voltage directly. Only after that does it search the frequency upward toward the requested target.

After every step the controller waits a programmable number of settle cycles, during which sensor flags are ignored. It then opens a short sampling window in which any flag is held in a sticky bit.

A second voltage code, for the critical portion of the logic, is derived by a fixed rule from the frequency code. That code never takes part in the search.

Top module: `vfTuner`

## Requirements
- R1: `reqReady` is high only while the controller is idle. A request is taken in the cycle that has both `reqValid` and `reqReady` high, and `reqReady` is low in the next cycle. When the sequence ends, `done` is high for exactly one cycle.
- R2: On a save request (`reqBoost`=0) the frequency code is set directly to the clamped target, but only if that target is lower than the current code (it is never raised). Any voltage decrease happens only after this frequency change.
- R3: On a boost request (`reqBoost`=1) the voltage code is raised directly to `cfgVMax`; if it is already above `cfgVMax` it is left as is. Only after that does the frequency code increase.
- R4: `sensorEn` is high before the first risky step and throughout the search. It is low in the cycle where `done` is high. A voltage decrease or frequency increase never happens while `sensorEn` is low.
- R5: Each search step changes the searched code by exactly one: the voltage goes down by 1 on a save request, and the frequency goes up by 1 on a boost request.
- R6: The search stops after the first step whose sampling window sees any bit of `sensorFlags` set; every flag bit has the same effect. On a save request the voltage is then raised by `cfgVMargin`, saturating at `cfgVMax`.
- R7: When a boost search stops on a flag, the frequency is lowered by `cfgFMargin`, saturating at `cfgFMin` with no wrap-around.
- R8: After every step the controller waits `cfgSettle`+1 cycles, and flags raised in that time are ignored. Only flags seen in the following `SAMPLE_CYC`-cycle window count.
- R9: If the searched code is already at its limit with no flag, the search stops there and no margin is applied: the limit is `cfgVMin` for a save request, or the clamped target for a boost request. `limitHit` then becomes 1. `limitHit` clears when the next request is accepted and stays 0 for a search that stops on a flag.
- R10: `vCrit` equals `CRIT_BASE` + (`freqCode` >> `CRIT_SHIFT`), saturating at the all-ones code. With the defaults this is 64 + `freqCode`/2.
- R11: The requested frequency is clamped to [`cfgFMin`, `cfgFMax`] when the request is accepted.
- R12: After reset, `vMain`=`RESET_V` (200), `freqCode`=`RESET_F` (100), `sensorEn`=0, `done`=0, `limitHit`=0 and `reqReady`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller idle, ready to take a request |
| reqBoost | input | 1 | 1 = raise performance, 0 = save power |
| reqFreq | input | FW | Target frequency code |
| cfgVMin | input | VW | Lowest allowed main voltage code |
| cfgVMax | input | VW | Highest allowed main voltage code |
| cfgFMin | input | FW | Lowest allowed frequency code |
| cfgFMax | input | FW | Highest allowed frequency code |
| cfgVMargin | input | VW | Voltage back-off after a flag |
| cfgFMargin | input | FW | Frequency back-off after a flag |
| cfgSettle | input | SW | Settle cycles after each step, minus one |
| sensorFlags | input | NS | Delay-error prediction flags |
| sensorEn | output | 1 | Sensor enable |
| vMain | output | VW | Main-rail voltage code |
| vCrit | output | VW | Critical-portion voltage code |
| freqCode | output | FW | Clock frequency code |
| done | output | 1 | One-cycle completion pulse |
| limitHit | output | 1 | Last search ended at a limit without a flag |

## Verification
The bench targets the points where a plausible design could go wrong.

- **Settle-window glitch.** A sensor glitch is injected right after every code change. A design that sampled during settling would stop about ten steps early, at a higher voltage.
- **Back-off saturation.** Margins are applied where they would cross `cfgVMax`, and where they would drop the frequency below `cfgFMin`. A design without saturation would leave the voltage above its limit, or wrap the frequency code around to a large value.
- **Limit stops.** Searches are started exactly at their limit: a voltage already at `cfgVMin`, and a boost target below the current frequency. These expose a design that steps once past the limit, applies a margin anyway, or leaves `limitHit` stale into the next request.
- **Ordering and step size.** A per-cycle monitor checks every step for ordering, for sensors being enabled, and for a step of exactly one code.

// File: rtl/vfTunerPkg.sv
package vfTunerPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DIRECT, ST_ENSENS, ST_CHECK, ST_SETTLE, ST_SAMPLE, ST_DECIDE, ST_FINISH
  } vfState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;      // latch request
    logic direct;    // apply the safe, unsupervised move
    logic senOn;     // enable sensors
    logic senOff;    // disable sensors
    logic step;      // one LSB risky step, clears sticky flag
    logic capture;   // sampling window open
    logic restore;   // apply back-off margin
    logic setLimit;  // search ended at a limit
  } vfStrobe_t;
endpackage

// File: rtl/vfTunerCtl.sv
module vfTunerCtl
  import vfTunerPkg::*;
#(
  parameter int SW = 4,
  parameter int SAMPLE_CYC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          atLimit,
  input  logic          sticky,
  input  logic [SW-1:0] cfgSettle,
  output logic          reqReady,
  output logic          done,
  output vfStrobe_t     stb
);
  localparam int SCW  = $clog2(SAMPLE_CYC + 1);
  localparam int CNTW = (SW > SCW) ? SW : SCW;

  vfState_t state, nextState;
  logic [CNTW-1:0] cnt;

  always_comb begin
    nextState = state;
    stb       = '0;
    reqReady  = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.load  = 1'b1;
          nextState = ST_DIRECT;
        end
      end
      ST_DIRECT: begin
        stb.direct = 1'b1;
        nextState  = ST_ENSENS;
      end
      ST_ENSENS: begin
        stb.senOn = 1'b1;
        nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (atLimit) begin
          stb.setLimit = 1'b1;
          stb.senOff   = 1'b1;
          nextState    = ST_FINISH;
        end else begin
          stb.step  = 1'b1;
          nextState = ST_SETTLE;
        end
      end
      ST_SETTLE: if (cnt == '0) nextState = ST_SAMPLE;
      ST_SAMPLE: begin
        stb.capture = 1'b1;
        if (cnt == '0) nextState = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (sticky) begin
          stb.restore = 1'b1;
          stb.senOff  = 1'b1;
          nextState   = ST_FINISH;
        end else begin
          nextState = ST_CHECK;
        end
      end
      ST_FINISH: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (stb.step)
        cnt <= CNTW'(cfgSettle);
      else if (state == ST_SETTLE && cnt == '0)
        cnt <= CNTW'(SAMPLE_CYC - 1);
      else if ((state == ST_SETTLE || state == ST_SAMPLE) && cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R1
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (reqReady && !done));
endmodule

// File: rtl/vfTunerDp.sv
module vfTunerDp
  import vfTunerPkg::*;
#(
  parameter int VW = 8,
  parameter int FW = 8,
  parameter int NS = 4,
  parameter int RESET_V = 200,
  parameter int RESET_F = 100,
  parameter int CRIT_BASE = 64,
  parameter int CRIT_SHIFT = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  vfStrobe_t     stb,
  input  logic          reqBoost,
  input  logic [FW-1:0] reqFreq,
  input  logic [VW-1:0] cfgVMin,
  input  logic [VW-1:0] cfgVMax,
  input  logic [FW-1:0] cfgFMin,
  input  logic [FW-1:0] cfgFMax,
  input  logic [VW-1:0] cfgVMargin,
  input  logic [FW-1:0] cfgFMargin,
  input  logic [NS-1:0] sensorFlags,
  output logic          atLimit,
  output logic          sticky,
  output logic          sensorEn,
  output logic [VW-1:0] vMain,
  output logic [VW-1:0] vCrit,
  output logic [FW-1:0] freqCode,
  output logic          limitHit
);
  logic          boostMode;
  logic [FW-1:0] tgtFreq, tgtClamped;
  logic [VW:0]   vUpSum, critSum;
  logic [FW:0]   fFloor;
  logic [VW-1:0] vRestored;
  logic [FW-1:0] fRestored;

  always_comb begin
    if (reqFreq < cfgFMin)      tgtClamped = cfgFMin;
    else if (reqFreq > cfgFMax) tgtClamped = cfgFMax;
    else                        tgtClamped = reqFreq;

    vUpSum    = {1'b0, vMain} + {1'b0, cfgVMargin};
    vRestored = (vUpSum > {1'b0, cfgVMax}) ? cfgVMax : vUpSum[VW-1:0];

    fFloor    = {1'b0, cfgFMin} + {1'b0, cfgFMargin};
    fRestored = ({1'b0, freqCode} < fFloor) ? cfgFMin : freqCode - cfgFMargin;

    atLimit   = boostMode ? (freqCode >= tgtFreq) : (vMain <= cfgVMin);

    critSum   = (VW+1)'(CRIT_BASE) + (VW+1)'(freqCode >> CRIT_SHIFT);
    vCrit     = critSum[VW] ? {VW{1'b1}} : critSum[VW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      boostMode <= 1'b0;
      tgtFreq   <= '0;
      vMain     <= VW'(RESET_V);
      freqCode  <= FW'(RESET_F);
      sensorEn  <= 1'b0;
      sticky    <= 1'b0;
      limitHit  <= 1'b0;
    end else begin
      if (stb.load) begin
        boostMode <= reqBoost;
        tgtFreq   <= tgtClamped;
        limitHit  <= 1'b0;
      end
      if (stb.direct) begin
        if (boostMode && vMain < cfgVMax)      vMain    <= cfgVMax;
        if (!boostMode && tgtFreq < freqCode)  freqCode <= tgtFreq;
      end
      if (stb.senOn)  sensorEn <= 1'b1;
      if (stb.senOff) sensorEn <= 1'b0;
      if (stb.step) begin
        sticky <= 1'b0;
        if (boostMode) freqCode <= freqCode + 1'b1;
        else           vMain    <= vMain - 1'b1;
      end else if (stb.capture && |sensorFlags) begin
        sticky <= 1'b1;
      end
      if (stb.restore) begin
        if (boostMode) freqCode <= fRestored;
        else           vMain    <= vRestored;
      end
      if (stb.setLimit) limitHit <= 1'b1;
    end
  end

  // R5
  v_single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vMain < $past(vMain)) |-> (($past(vMain) == vMain + 1'b1) && $past(sensorEn)));
  // R5
  f_single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode > $past(freqCode)) |-> (($past(freqCode) + 1'b1 == freqCode) && $past(sensorEn)));
  // R4
  sensors_armed_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sensorEn) |-> ($stable(vMain) && $stable(freqCode)));
  // R9
  limit_only_at_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(limitHit) |-> ($stable(vMain) && $stable(freqCode)));
endmodule

// File: rtl/vfTuner.sv
module vfTuner
  import vfTunerPkg::*;
#(
  parameter int VW = 8,
  parameter int FW = 8,
  parameter int NS = 4,
  parameter int SW = 4,
  parameter int SAMPLE_CYC = 2,
  parameter int RESET_V = 200,
  parameter int RESET_F = 100,
  parameter int CRIT_BASE = 64,
  parameter int CRIT_SHIFT = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqBoost,
  input  logic [FW-1:0] reqFreq,
  input  logic [VW-1:0] cfgVMin,
  input  logic [VW-1:0] cfgVMax,
  input  logic [FW-1:0] cfgFMin,
  input  logic [FW-1:0] cfgFMax,
  input  logic [VW-1:0] cfgVMargin,
  input  logic [FW-1:0] cfgFMargin,
  input  logic [SW-1:0] cfgSettle,
  input  logic [NS-1:0] sensorFlags,
  output logic          sensorEn,
  output logic [VW-1:0] vMain,
  output logic [VW-1:0] vCrit,
  output logic [FW-1:0] freqCode,
  output logic          done,
  output logic          limitHit
);
  vfStrobe_t stb;
  logic atLimit, sticky;

  vfTunerCtl #(.SW(SW), .SAMPLE_CYC(SAMPLE_CYC)) ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .atLimit(atLimit), .sticky(sticky),
    .cfgSettle(cfgSettle), .reqReady(reqReady), .done(done), .stb(stb)
  );

  vfTunerDp #(
    .VW(VW), .FW(FW), .NS(NS), .RESET_V(RESET_V), .RESET_F(RESET_F),
    .CRIT_BASE(CRIT_BASE), .CRIT_SHIFT(CRIT_SHIFT)
  ) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqBoost(reqBoost), .reqFreq(reqFreq),
    .cfgVMin(cfgVMin), .cfgVMax(cfgVMax), .cfgFMin(cfgFMin), .cfgFMax(cfgFMax),
    .cfgVMargin(cfgVMargin), .cfgFMargin(cfgFMargin), .sensorFlags(sensorFlags),
    .atLimit(atLimit), .sticky(sticky), .sensorEn(sensorEn), .vMain(vMain),
    .vCrit(vCrit), .freqCode(freqCode), .limitHit(limitHit)
  );

  // R4
  quiet_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !sensorEn);
endmodule

// File: tb/vfTuner_test.sv
module vfTuner_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqBoost = 1'b0;
  logic [7:0] reqFreq = '0;
  logic [7:0] cfgVMin = 8'd40, cfgVMax = 8'd220, cfgFMin = 8'd20, cfgFMax = 8'd200;
  logic [7:0] cfgVMargin = 8'd5, cfgFMargin = 8'd4;
  logic [3:0] cfgSettle = 4'd3;
  logic [3:0] sensorFlags;
  logic       reqReady, sensorEn, done, limitHit;
  logic [7:0] vMain, vCrit, freqCode;

  logic [7:0] vTh = 8'd0, fTh = 8'd255;
  logic       glitchOn = 1'b0, glitch = 1'b0;
  int         nChecks = 0, nErr = 0;

  typedef struct {
    int    v;
    int    f;
    int    c;
    int    lim;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  int  mV = 200, mF = 100;
  int  curExpV = 200, curExpF = 100;
  bit  armed = 1'b0;
  int  prevV = 0, prevF = 0;
  bit  prevEn = 1'b0, prevDone = 1'b0;
  logic [7:0] gV = '0, gF = '0;

  vfTuner uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqBoost(reqBoost),
    .reqFreq(reqFreq), .cfgVMin(cfgVMin), .cfgVMax(cfgVMax), .cfgFMin(cfgFMin),
    .cfgFMax(cfgFMax), .cfgVMargin(cfgVMargin), .cfgFMargin(cfgFMargin),
    .cfgSettle(cfgSettle), .sensorFlags(sensorFlags), .sensorEn(sensorEn),
    .vMain(vMain), .vCrit(vCrit), .freqCode(freqCode), .done(done), .limitHit(limitHit)
  );

  always #10 clk = ~clk;

  // delay sensor model: bit0 voltage too low, bit2 frequency too high, bit1 glitch
  assign sensorFlags = {1'b0, freqCode > fTh, glitch, vMain < vTh};

  // a one-cycle glitch right after each code change, which falls inside settling
  always @(negedge clk) begin
    glitch <= glitchOn && ((vMain != gV) || (freqCode != gF));
    gV <= vMain;
    gF <= freqCode;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on done, per-step ordering checks
  always @(negedge clk) begin
    if (armed) begin
      if (done) begin
        if (expQ.size() == 0) chk("R1 unexpected done", 1, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          chk({e.tag, " vMain"}, vMain, e.v);
          chk({e.tag, " freqCode"}, freqCode, e.f);
          chk({e.tag, " R10 vCrit"}, vCrit, e.c);
          chk({e.tag, " R9 limitHit"}, limitHit, e.lim);
          chk({e.tag, " R4 sensorEn low at done"}, sensorEn, 0);
        end
        if (prevDone) chk("R1 done longer than one cycle", 1, 0);
      end
      if (vMain < prevV) begin
        chk("R5 voltage step size", prevV - vMain, 1);
        chk("R4 sensors on during voltage step", prevEn, 1);
        chk("R2 frequency lowered before voltage", freqCode, curExpF);
      end
      if (freqCode > prevF) begin
        chk("R5 frequency step size", freqCode - prevF, 1);
        chk("R4 sensors on during frequency step", prevEn, 1);
        chk("R3 voltage raised before frequency", vMain, curExpV);
      end
    end
    prevV    = vMain;
    prevF    = freqCode;
    prevEn   = sensorEn;
    prevDone = done;
  end

  task automatic runReq(input bit boost, input int tgt, input string tag);
    int tc;
    int lim;
    int vMaxI, vMinI, fMinI;
    vMaxI = cfgVMax; vMinI = cfgVMin; fMinI = cfgFMin;
    tc  = (tgt < cfgFMin) ? cfgFMin : (tgt > cfgFMax) ? cfgFMax : tgt;
    lim = 0;
    if (!boost) begin
      if (tc < mF) mF = tc;
      curExpF = mF;
      forever begin
        if (mV <= vMinI) begin lim = 1; break; end
        mV--;
        if (mV < vTh || mF > fTh) begin
          mV = (mV + cfgVMargin > vMaxI) ? vMaxI : mV + cfgVMargin;
          break;
        end
      end
    end else begin
      if (mV < vMaxI) mV = vMaxI;
      curExpV = mV;
      forever begin
        if (mF >= tc) begin lim = 1; break; end
        mF++;
        if (mV < vTh || mF > fTh) begin
          mF = (mF < fMinI + cfgFMargin) ? fMinI : mF - cfgFMargin;
          break;
        end
      end
    end
    expQ.push_back('{v: mV, f: mF, c: ((64 + (mF >> 1)) > 255) ? 255 : 64 + (mF >> 1),
                     lim: lim, tag: tag});
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqBoost = boost;
    reqFreq  = 8'(tgt);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " R1 ready low while busy"}, reqReady, 0);
    chk({tag, " R9 limitHit cleared on accept"}, limitHit, 0);
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    chk("R12 reset vMain", vMain, 200);
    chk("R12 reset freqCode", freqCode, 100);
    chk("R12 reset vCrit", vCrit, 114);
    chk("R12 reset reqReady", reqReady, 1);
    chk("R12 reset sensorEn", sensorEn, 0);
    chk("R12 reset done", done, 0);
    chk("R12 reset limitHit", limitHit, 0);
    prevV = vMain; prevF = freqCode; armed = 1'b1;

    // R2 R6: save, lower freq to 60, voltage flags below 150
    vTh = 8'd150; fTh = 8'd255;
    runReq(1'b0, 60, "R2 R6 save flag");
    // R9 R2 R11: target above range -> clamp 200, never raised; no flag to vMin
    vTh = 8'd0;
    runReq(1'b0, 250, "R9 R11 save to vMin");
    // R9: already at vMin -> immediate limit stop
    runReq(1'b0, 60, "R9 save at limit");
    // R3 R9: boost, voltage direct to max, freq reaches target
    runReq(1'b1, 90, "R3 R9 boost to target");
    // R6 saturation: flag at 217, +5 saturates at 220
    vTh = 8'd218;
    runReq(1'b0, 90, "R6 save margin saturation");
    // R11 R9: boost target below fMin -> clamp 20, already above -> limit
    vTh = 8'd0;
    runReq(1'b1, 10, "R11 boost clamp low");
    // R7: boost with flag above 150, back off by 4
    fTh = 8'd150;
    runReq(1'b1, 180, "R7 boost flag");
    // R7 saturation at fMin
    cfgFMargin = 8'd200;
    runReq(1'b1, 180, "R7 boost margin saturation");
    // R8: glitches during settling must be ignored
    cfgFMargin = 8'd4;
    glitchOn = 1'b1;
    vTh = 8'd210;
    runReq(1'b0, 20, "R8 settle glitch ignored");
    glitchOn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle ready after runs", reqReady, 1);
    chk("R4 sensors off when idle", sensorEn, 0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule